// File: doc/BRIEF.md
# Windowed Cell Capture Buffer

The block records a window of whole fixed-length cells from a received byte stream into on-chip memory, positioned around a trigger. The stream arrives one byte per valid cycle, with a flag marking the first byte of each cell and a small vector of per-cell event flags raised by upstream checkers. Software-facing logic arms the block, chooses the trigger source at that moment, and reads the stored cells back through a random-access byte read port after the done flag rises.

Two capture modes exist. In manual mode nothing is stored until a trigger pulse arrives, and then the next `DEPTH` whole cells are written to indices 0 upward. In event mode the block writes every whole cell into a circular buffer from the moment it is armed. The first cell that carries an enabled event, once enough history is held, becomes the trigger cell. The block then stores a fixed number of further cells and stops, so that the memory holds `PRE` cells before the trigger cell, the trigger cell itself, and `DEPTH-PRE-1` cells after it. With the defaults this is 1500 cells of 53 bytes, split 749 / 1 / 750.

Top module: `cell_capture_buf`

## Requirements
- R1: After reset `capDone` is 0 and `trigIdx` is 0, and no cell is stored until `arm` has been pulsed.
- R2: Only whole cells are stored. A cell starts on a valid byte with `inSoc`=1 and is complete after `CELL_BYTES` valid bytes. A new start flag inside a cell abandons the partial cell. Valid bytes that arrive without a preceding start flag are dropped.
- R3: Manual mode (`trigSrc`=0 at arm): after a `manTrig` pulse, the next `DEPTH` cells whose start byte arrives strictly after the pulse are stored in order at indices 0 to `DEPTH-1`. `trigIdx` reads 0, and `capDone` rises on the cycle after the last byte of the last of those cells.
- R4: Event mode (`trigSrc`=1 at arm): a cell is a trigger candidate when its event flags ANDed with `evtMask` are nonzero. A flag raised on any byte of the cell counts. Flag bit 0 is cell loss, bit 1 header error, bit 2 payload-pattern error, and bit 3 sequence-number byte error.
- R5: An event-mode trigger is accepted only when at least `PRE` cells have already been stored since the arm. Candidates before that point are ignored and capture continues.
- R6: In event mode `trigIdx` is the memory index of the trigger cell. The cell k places earlier is at (`trigIdx`-k) mod `DEPTH` for k=1..`PRE`, and the cell k places later is at (`trigIdx`+k) mod `DEPTH`. `capDone` rises after the `DEPTH-PRE-1`-th later cell.
- R7: While `capDone` is 1, no cell is written and both trigger sources are ignored. A new `arm` clears `capDone` and restarts capture.
- R8: `manTrig` has no effect in event mode, and event flags have no effect in manual mode.
- R9: A cell whose only raised flags are masked off by `evtMask` does not trigger.
- R10: `rdData` returns byte `rdByte` (byte 0 is the first received) of stored cell `rdCell`, one clock after the address is applied.
- R11: When `arm` and `manTrig` are high in the same cycle, the arm takes effect and the trigger pulse is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Received byte |
| inValid | input | 1 | `inByte` is valid this cycle |
| inSoc | input | 1 | The valid byte is the first of a cell |
| evtFlags | input | NEVT | Per-cell event flags, sampled on valid bytes |
| evtMask | input | NEVT | Enables for each event flag |
| arm | input | 1 | Start a new capture (pulse) |
| trigSrc | input | 1 | Trigger source sampled at arm: 0 manual, 1 event |
| manTrig | input | 1 | Manual trigger request (pulse) |
| rdCell | input | IDXW | Read address: cell index |
| rdByte | input | BW | Read address: byte within the cell |
| rdData | output | 8 | Read data, one cycle latency |
| capDone | output | 1 | Capture window complete |
| trigIdx | output | IDXW | Memory index of the trigger cell |

## Verification
Two pairs of functions can meet in one cycle. The first is an arm and a manual trigger. The bench raises both in the same cycle, streams a full buffer's worth of cells, and expects no completion, because the trigger must have been discarded. The second is an event cell completing exactly when the pre-trigger history reaches its threshold. The bench places enabled events on the cell just before the threshold and on a masked-off cell, and then judges the trigger position from `trigIdx` and from the wrapped placement of the cells read back.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // strobes from the capture control to the datapath
  typedef struct packed {
    logic gateOpen;   // a cell starting this cycle may be stored
    logic wrEn;       // write the cell completing this cycle
    logic ptrClr;     // restart write pointer
    logic trigLatch;  // record current write pointer as trigger position
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } capState_t;

endpackage

// File: rtl/cap_cell_asm.sv
module cap_cell_asm #(
  parameter int CELL_BYTES = 53,
  parameter int NEVT       = 4,
  localparam int BW        = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1,
  localparam int CELL_W    = CELL_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  input  logic              inSoc,
  input  logic [NEVT-1:0]   evtFlags,
  input  logic [NEVT-1:0]   evtMask,
  input  logic              gateOpen,
  output logic              cellDone,
  output logic              cellGated,
  output logic              cellEvt,
  output logic [CELL_W-1:0] cellWord
);

  localparam logic [BW-1:0] LAST = BW'(CELL_BYTES - 1);

  logic [CELL_W-1:0] cellBuf;
  logic [BW-1:0]     byteCnt;
  logic              inCell;
  logic [NEVT-1:0]   evtAcc;

  always_comb begin
    cellDone = inValid && !inSoc && inCell && (byteCnt == LAST);
    cellEvt  = |((evtAcc | evtFlags) & evtMask);
    cellWord = cellBuf;
    cellWord[{byteCnt, 3'b000} +: 8] = inByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt   <= '0;
      inCell    <= 1'b0;
      evtAcc    <= '0;
      cellGated <= 1'b0;
      cellBuf   <= '0;
    end else if (inValid) begin
      if (inSoc) begin
        cellBuf[7:0] <= inByte;
        byteCnt      <= BW'(1);
        inCell       <= 1'b1;
        evtAcc       <= evtFlags;
        cellGated    <= gateOpen;
      end else if (inCell) begin
        cellBuf[{byteCnt, 3'b000} +: 8] <= inByte;
        evtAcc <= evtAcc | evtFlags;
        if (byteCnt == LAST) begin
          byteCnt <= '0;
          inCell  <= 1'b0;
        end else begin
          byteCnt <= byteCnt + BW'(1);
        end
      end
    end
  end

  AST_BYTE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST); // R2

  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !inCell |-> byteCnt == '0); // R2

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH     = 1500,
  parameter int PRE       = 749,
  localparam int IDXW     = $clog2(DEPTH),
  localparam int POST     = DEPTH - PRE - 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       arm,
  input  logic       trigSrc,
  input  logic       manTrig,
  input  logic       cellDone,
  input  logic       cellGated,
  input  logic       cellEvt,
  output ctlStrobe_t stb,
  output logic       capDone
);

  localparam logic [IDXW-1:0] PRE_N   = IDXW'(PRE);
  localparam logic [IDXW-1:0] MAN_END = IDXW'(DEPTH - 1);
  localparam logic [IDXW-1:0] EVT_END = IDXW'(POST - 1);

  capState_t       st;
  logic            modeEvt;
  logic [IDXW-1:0] heldCnt;
  logic [IDXW-1:0] postCnt;
  logic            active;
  logic            trigHit;
  logic [IDXW-1:0] postEnd;

  always_comb begin
    active        = (st == ST_FILL) || (st == ST_POST);
    postEnd       = modeEvt ? EVT_END : MAN_END;
    stb.ptrClr    = arm;
    stb.wrEn      = !arm && active && cellDone && cellGated;
    stb.gateOpen  = !arm && (modeEvt ? active : (st == ST_POST));
    if (modeEvt)
      trigHit = !arm && (st == ST_FILL) && stb.wrEn && cellEvt && (heldCnt == PRE_N);
    else
      trigHit = !arm && (st == ST_FILL) && manTrig;
    stb.trigLatch = trigHit;
    capDone       = (st == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      modeEvt <= 1'b0;
      heldCnt <= '0;
      postCnt <= '0;
    end else if (arm) begin
      st      <= ST_FILL;
      modeEvt <= trigSrc;
      heldCnt <= '0;
      postCnt <= '0;
    end else begin
      case (st)
        ST_FILL: begin
          if (trigHit) begin
            st      <= ST_POST;
            postCnt <= '0;
          end else if (stb.wrEn && heldCnt != PRE_N) begin
            heldCnt <= heldCnt + IDXW'(1);
          end
        end
        ST_POST: begin
          if (stb.wrEn) begin
            if (postCnt == postEnd) st <= ST_DONE;
            else postCnt <= postCnt + IDXW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capDone) |-> $past(stb.wrEn)); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    capDone && !arm |=> capDone); // R7

  AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    capDone |-> !stb.wrEn && !stb.trigLatch); // R7

  AST_ARM_WINS: assert property (@(posedge clk) disable iff (!rstN)
    arm |-> !stb.trigLatch && !stb.wrEn); // R11

  AST_EVT_HISTORY: assert property (@(posedge clk) disable iff (!rstN)
    stb.trigLatch && modeEvt |-> heldCnt == PRE_N && cellEvt); // R5

endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int DEPTH      = 1500,
  parameter int NEVT       = 4,
  localparam int IDXW      = $clog2(DEPTH),
  localparam int BW        = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1,
  localparam int CELL_W    = CELL_BYTES * 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      inByte,
  input  logic            inValid,
  input  logic            inSoc,
  input  logic [NEVT-1:0] evtFlags,
  input  logic [NEVT-1:0] evtMask,
  input  ctlStrobe_t      stb,
  output logic            cellDone,
  output logic            cellGated,
  output logic            cellEvt,
  input  logic [IDXW-1:0] rdCell,
  input  logic [BW-1:0]   rdByte,
  output logic [7:0]      rdData,
  output logic [IDXW-1:0] trigIdx
);

  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(DEPTH - 1);

  logic [CELL_W-1:0] cellWord;
  logic [CELL_W-1:0] mem [DEPTH];
  logic [CELL_W-1:0] rdWord;
  logic [IDXW-1:0]   wrPtr;

  cap_cell_asm #(
    .CELL_BYTES(CELL_BYTES),
    .NEVT      (NEVT)
  ) u_asm (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .inValid  (inValid),
    .inSoc    (inSoc),
    .evtFlags (evtFlags),
    .evtMask  (evtMask),
    .gateOpen (stb.gateOpen),
    .cellDone (cellDone),
    .cellGated(cellGated),
    .cellEvt  (cellEvt),
    .cellWord (cellWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      trigIdx <= '0;
    end else begin
      if (stb.trigLatch) trigIdx <= wrPtr;
      if (stb.ptrClr) wrPtr <= '0;
      else if (stb.wrEn) wrPtr <= (wrPtr == TOP_IDX) ? '0 : wrPtr + IDXW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrPtr] <= cellWord;
  end

  always_comb rdWord = mem[rdCell];

  always_ff @(posedge clk) begin
    rdData <= rdWord[{rdByte, 3'b000} +: 8];
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= TOP_IDX); // R6

  AST_WHOLE_CELL: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> cellDone && cellGated); // R2

  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.trigLatch |=> $stable(trigIdx)); // R7

endmodule

// File: rtl/cell_capture_buf.sv
module cell_capture_buf
  import cap_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int DEPTH      = 1500,
  parameter int PRE        = 749,
  parameter int NEVT       = 4,
  localparam int IDXW      = $clog2(DEPTH),
  localparam int BW        = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      inByte,
  input  logic            inValid,
  input  logic            inSoc,
  input  logic [NEVT-1:0] evtFlags,
  input  logic [NEVT-1:0] evtMask,
  input  logic            arm,
  input  logic            trigSrc,
  input  logic            manTrig,
  input  logic [IDXW-1:0] rdCell,
  input  logic [BW-1:0]   rdByte,
  output logic [7:0]      rdData,
  output logic            capDone,
  output logic [IDXW-1:0] trigIdx
);

  ctlStrobe_t stb;
  logic cellDone;
  logic cellGated;
  logic cellEvt;

  cap_ctrl #(
    .DEPTH(DEPTH),
    .PRE  (PRE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .arm      (arm),
    .trigSrc  (trigSrc),
    .manTrig  (manTrig),
    .cellDone (cellDone),
    .cellGated(cellGated),
    .cellEvt  (cellEvt),
    .stb      (stb),
    .capDone  (capDone)
  );

  cap_datapath #(
    .CELL_BYTES(CELL_BYTES),
    .DEPTH     (DEPTH),
    .NEVT      (NEVT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .inValid  (inValid),
    .inSoc    (inSoc),
    .evtFlags (evtFlags),
    .evtMask  (evtMask),
    .stb      (stb),
    .cellDone (cellDone),
    .cellGated(cellGated),
    .cellEvt  (cellEvt),
    .rdCell   (rdCell),
    .rdByte   (rdByte),
    .rdData   (rdData),
    .trigIdx  (trigIdx)
  );

endmodule

// File: tb/cell_capture_buf_tb.sv
module cell_capture_buf_tb;

  localparam int CB    = 4;
  localparam int DEP   = 10;
  localparam int PR    = 4;
  localparam int IDXW  = $clog2(DEP);
  localparam int BW    = $clog2(CB);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [7:0]      inByte = '0;
  logic            inValid = 1'b0;
  logic            inSoc = 1'b0;
  logic [3:0]      evtFlags = '0;
  logic [3:0]      evtMask = 4'b1111;
  logic            arm = 1'b0;
  logic            trigSrc = 1'b0;
  logic            manTrig = 1'b0;
  logic [IDXW-1:0] rdCell = '0;
  logic [BW-1:0]   rdByte = '0;
  logic [7:0]      rdData;
  logic            capDone;
  logic [IDXW-1:0] trigIdx;

  int nChk = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cell_capture_buf #(
    .CELL_BYTES(CB),
    .DEPTH     (DEP),
    .PRE       (PR),
    .NEVT      (4)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid), .inSoc(inSoc),
    .evtFlags(evtFlags), .evtMask(evtMask), .arm(arm), .trigSrc(trigSrc),
    .manTrig(manTrig), .rdCell(rdCell), .rdByte(rdByte), .rdData(rdData),
    .capDone(capDone), .trigIdx(trigIdx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cellOf(input int tag);
    logic [31:0] w;
    for (int i = 0; i < CB; i++) w[i*8 +: 8] = {tag[5:0], i[1:0]};
    return w;
  endfunction

  // send nBytes of a cell; evt raised on byte evtPos
  task automatic sendBytes(input int tag, input int nBytes, input bit soc,
                           input logic [3:0] evt, input int evtPos);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      inValid  = 1'b1;
      inSoc    = soc && (i == 0);
      inByte   = {tag[5:0], i[1:0]};
      evtFlags = (i == evtPos) ? evt : 4'b0000;
    end
    @(negedge clk);
    inValid = 1'b0; inSoc = 1'b0; evtFlags = '0;
  endtask

  task automatic sendCell(input int tag, input logic [3:0] evt, input int evtPos);
    sendBytes(tag, CB, 1'b1, evt, evtPos);
  endtask

  task automatic readCell(input int idx, output logic [31:0] w);
    for (int b = 0; b < CB; b++) begin
      @(negedge clk);
      rdCell = IDXW'(idx); rdByte = BW'(b);
      @(negedge clk);
      w[b*8 +: 8] = rdData;
    end
  endtask

  task automatic doArm(input bit src, input bit withTrig);
    @(negedge clk);
    arm = 1'b1; trigSrc = src; manTrig = withTrig;
    @(negedge clk);
    arm = 1'b0; manTrig = 1'b0;
  endtask

  task automatic pulseTrig();
    @(negedge clk);
    manTrig = 1'b1;
    @(negedge clk);
    manTrig = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(capDone == 1'b0, "R1 done after reset", capDone, 0);
    check(trigIdx == '0, "R1 trigIdx after reset", trigIdx, 0);
    // cells before any arm and a trigger: nothing may complete
    for (int k = 0; k < DEP + 1; k++) sendCell(60, 4'b0001, 0);
    pulseTrig();
    for (int k = 0; k < DEP + 1; k++) sendCell(61, 4'b0000, 0);
    check(capDone == 1'b0, "R1 no capture before arm", capDone, 0);
  endtask

  task automatic t_manual();
    logic [31:0] w;
    doArm(1'b0, 1'b0);
    sendCell(1, 4'b1111, 1);   // before trigger, event ignored (R8)
    sendCell(2, 4'b0000, 0);
    check(capDone == 1'b0, "R8 event ignored in manual mode", capDone, 0);
    pulseTrig();
    sendBytes(50, 2, 1'b1, 4'b0, 0);  // partial cell, abandoned
    for (int k = 0; k < DEP; k++) begin
      sendCell(10 + k, 4'b0000, 0);
      if (k == 2) sendBytes(51, 2, 1'b0, 4'b0, 0);  // orphan bytes
      if (k == DEP - 2)
        check(capDone == 1'b0, "R3 not done one cell early", capDone, 0);
    end
    check(capDone == 1'b1, "R3 done after DEPTH cells", capDone, 1);
    check(trigIdx == '0, "R3 manual trigIdx", trigIdx, 0);
    for (int k = 0; k < DEP; k++) begin
      readCell(k, w);
      check(w == cellOf(10 + k), "R3 R2 R10 manual cell content", w, cellOf(10 + k));
    end
  endtask

  task automatic t_event();
    logic [31:0] w;
    evtMask = 4'b1011;
    doArm(1'b1, 1'b0);
    for (int k = 0; k < 7; k++) begin
      if (k == 3) sendCell(30 + k, 4'b0001, 1);      // held=3 < PRE: ignored (R5)
      else if (k == 5) sendCell(30 + k, 4'b0100, 2); // masked event (R9)
      else if (k == 6) begin
        pulseTrig();                                 // manual ignored in event mode (R8)
        sendCell(30 + k, 4'b0000, 0);
      end
      else sendCell(30 + k, 4'b0000, 0);
    end
    check(capDone == 1'b0, "R5 R9 no early trigger", capDone, 0);
    sendCell(37, 4'b1000, 2);  // trigger, flag on a middle byte (R4)
    for (int k = 1; k <= DEP - PR - 1; k++) begin
      if (k == DEP - PR - 1)
        check(capDone == 1'b0, "R6 not done one cell early", capDone, 0);
      sendCell(37 + k, 4'b0000, 0);
    end
    check(capDone == 1'b1, "R6 done after post cells", capDone, 1);
    check(trigIdx == IDXW'(7), "R4 R5 trigger index", trigIdx, 7);
    for (int k = 0; k <= PR; k++) begin
      readCell((7 - k + DEP) % DEP, w);
      check(w == cellOf(37 - k), "R6 pre-trigger cell", w, cellOf(37 - k));
    end
    for (int k = 1; k <= DEP - PR - 1; k++) begin
      readCell((7 + k) % DEP, w);
      check(w == cellOf(37 + k), "R6 post-trigger cell", w, cellOf(37 + k));
    end
    evtMask = 4'b1111;
  endtask

  task automatic t_after_done();
    logic [31:0] w;
    pulseTrig();
    for (int k = 0; k < 3; k++) sendCell(55, 4'b1111, 0);
    check(capDone == 1'b1, "R7 done holds", capDone, 1);
    check(trigIdx == IDXW'(7), "R7 trigIdx unchanged", trigIdx, 7);
    readCell(8, w);
    check(w == cellOf(38), "R7 no write after done", w, cellOf(38));
    readCell(0, w);
    check(w == cellOf(40), "R7 no write after done idx0", w, cellOf(40));
  endtask

  task automatic t_collide();
    logic [31:0] w;
    doArm(1'b0, 1'b1);
    check(capDone == 1'b0, "R7 arm clears done", capDone, 0);
    for (int k = 0; k < DEP; k++) sendCell(5, 4'b0000, 0);
    check(capDone == 1'b0, "R11 trigger with arm discarded", capDone, 0);
    pulseTrig();
    for (int k = 0; k < DEP; k++) sendCell(20 + k, 4'b0000, 0);
    check(capDone == 1'b1, "R11 later trigger works", capDone, 1);
    readCell(0, w);
    check(w == cellOf(20), "R11 first cell", w, cellOf(20));
    readCell(DEP - 1, w);
    check(w == cellOf(29), "R11 last cell", w, cellOf(29));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_manual();
    t_event();
    t_after_done();
    t_collide();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

endmodule